// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a target device on a two-wire serial bus (I2C). It sits in front of a 512-byte memory held in registers. It oversamples the clock and data lines with the system clock and finds bus start and stop events. It drives the data line only through an open-drain pull-down enable.

Every transfer opens with a command byte. That byte carries a fixed device-type code, a read or write flag and, for writes, the ninth bit of the memory address. A write transfer sends a low address byte next and then any number of data bytes. A read transfer returns bytes from the point where the address counter already stands. One 9-bit address counter serves both kinds of transfer, so a read with no address phase continues from where the last access stopped.

Top module: `eep_serial_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` = 0), the address counter is 0 and every memory byte reads back as 0x00.
- R2: A command byte whose bits 7..4 differ from 1010 is not acknowledged. Every later byte up to the next START is ignored: it is not acknowledged, it writes no memory and it leaves the counter unchanged.
- R3: A command byte with bits 7..4 = 1010 and bit 0 = 0 (write) is acknowledged. Its bit 1 is kept as address bit 8, and bits 3 and 2 have no effect.
- R4: The byte after an acknowledged write command is acknowledged and loads the counter with {bit 8 from the command, received byte}.
- R5: Each further byte in a write transfer is acknowledged and stored at the counter's address. The counter then advances by one at the end of that acknowledge slot.
- R6: After a command byte with bits 7..4 = 1010 and bit 0 = 1 (read) is acknowledged, the slave sends the byte at the counter's address, MSB first, and advances the counter for each byte it sends. Bits 3..1 of a read command do not change the address.
- R7: If the master leaves SDA high in the acknowledge slot after a read byte, the slave stops sending and keeps SDA released until the next START or STOP.
- R8: The counter wraps from 511 to 0, both in writes and in reads.
- R9: A START (SDA falls while SCL is high) restarts command decoding at any point, even inside a byte, and a partly received byte writes nothing. A STOP (SDA rises while SCL is high) returns the slave to idle.
- R10: `sda_oe_o` changes only while the synchronized SCL is low. Input bits are taken on SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired level) |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
In a streaming read, the fetch of the next byte from the array and the advance of the counter fall on the same clock edge. At address 511 this edge must read the byte at 511 while the counter rolls over to 0. The bench provokes this by writing a 256-byte block that starts at 384 and wraps past 511, then reading the whole block back in one sequential read. Each returned byte is judged against an arithmetic pattern of its address taken modulo 512, so a fetch that came after the increment would show up as a shifted byte exactly at the wrap.

// File: rtl/eep_pkg.sv
// Package: shared constants and state encoding for the serial EEPROM slave.
// Assumes byte-wide transfers and a 9-bit memory address.
package eep_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 9;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ACK_CMD,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WDATA,
        ST_ACK_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_DROP
    } eep_state_t;
endpackage

// File: rtl/eep_bus_sync.sv
// Module: brings SCL and SDA into the system clock domain and reports
// SCL edges and bus START/STOP events as one-cycle pulses.
// Assumes: STAGES >= 2; the bus is slow compared with clk.
module eep_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Purpose: synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Purpose: decode edges and bus conditions from current and previous samples.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/eep_addr_ctr.sv
// Module: memory address counter with parallel load and modulo increment.
// Assumes load and increment are never requested in the same cycle;
// load wins if they are.
module eep_addr_ctr #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    // Purpose: hold, load or advance the address (natural wrap at 2**AW).
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= load_val;
        else if (inc)  addr <= addr + 1'b1;
    end
endmodule

// File: rtl/eep_mem_array.sv
// Module: register-based byte array with one synchronous write port and
// an asynchronous read port. Cleared to zero by reset.
// Assumes 2**AW stays within a few thousand flops per bit.
module eep_mem_array #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: clear on reset, write one byte on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Purpose: combinational read at the shared address.
    always_comb rdata = mem[addr];
endmodule

// File: rtl/eep_serial_slave.sv
// Module: top of the two-wire serial EEPROM slave. Decodes the command byte,
// loads the address, writes received bytes and streams read bytes.
// Assumes the bus is oversampled by clk (at least about eight clk cycles per
// SCL phase) and that SDA drives are wired-AND outside this block.
module eep_serial_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = eep_pkg::DEV_TYPE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    import eep_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    eep_state_t        st, st_d;
    logic [CNT_W-1:0]  bitcnt, bit_d;
    logic [DATA_W-1:0] shreg, sh_d;
    logic [DATA_W-1:0] txreg, tx_d;
    logic              oe, oe_d;
    logic              a8, a8_d;
    logic              is_rd, rd_d;
    logic              mack, mack_d;

    logic              mem_we, ctr_inc, ctr_load;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] load_val;
    logic [DATA_W-1:0] rdata;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_addr_ctr #(.AW(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (load_val),
        .inc      (ctr_inc),
        .addr     (addr_q)
    );

    eep_mem_array #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (addr_q),
        .wdata (shreg),
        .rdata (rdata)
    );

    // Purpose: address formed from the captured high bit and the address byte.
    always_comb load_val = {a8, shreg};

    // Purpose: next-state and action decode of the byte-level protocol.
    always_comb begin
        st_d     = st;
        bit_d    = bitcnt;
        sh_d     = shreg;
        tx_d     = txreg;
        oe_d     = oe;
        a8_d     = a8;
        rd_d     = is_rd;
        mack_d   = mack;
        mem_we   = 1'b0;
        ctr_inc  = 1'b0;
        ctr_load = 1'b0;
        if (stop_det) begin
            st_d = ST_IDLE;
            oe_d = 1'b0;
        end else if (start_det) begin
            st_d  = ST_CMD;
            bit_d = '0;
            oe_d  = 1'b0;
        end else begin
            case (st)
                ST_CMD, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && bitcnt != CNT_FULL) begin
                        sh_d  = {shreg[DATA_W-2:0], sda_s};
                        bit_d = bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == CNT_FULL) begin
                        bit_d = '0;
                        if (st == ST_CMD) begin
                            if (shreg[7:4] == DEV_CODE) begin
                                oe_d = 1'b1;
                                a8_d = shreg[1];
                                rd_d = shreg[0];
                                st_d = ST_ACK_CMD;
                            end else begin
                                st_d = ST_DROP;
                            end
                        end else if (st == ST_ADDR) begin
                            ctr_load = 1'b1;
                            oe_d     = 1'b1;
                            st_d     = ST_ACK_ADDR;
                        end else begin
                            mem_we = 1'b1;
                            oe_d   = 1'b1;
                            st_d   = ST_ACK_WDATA;
                        end
                    end
                end
                ST_ACK_CMD: begin
                    if (scl_fall) begin
                        if (is_rd) begin
                            tx_d    = rdata;
                            ctr_inc = 1'b1;
                            oe_d    = ~rdata[DATA_W-1];
                            bit_d   = '0;
                            st_d    = ST_RDATA;
                        end else begin
                            oe_d = 1'b0;
                            st_d = ST_ADDR;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        oe_d = 1'b0;
                        st_d = ST_WDATA;
                    end
                end
                ST_ACK_WDATA: begin
                    if (scl_fall) begin
                        oe_d    = 1'b0;
                        ctr_inc = 1'b1;
                        st_d    = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bitcnt == CNT_LAST) begin
                            oe_d  = 1'b0;
                            bit_d = '0;
                            st_d  = ST_RACK;
                        end else begin
                            tx_d  = {txreg[DATA_W-2:0], 1'b0};
                            oe_d  = ~txreg[DATA_W-2];
                            bit_d = bitcnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            tx_d    = rdata;
                            ctr_inc = 1'b1;
                            oe_d    = ~rdata[DATA_W-1];
                            bit_d   = '0;
                            st_d    = ST_RDATA;
                        end else begin
                            oe_d = 1'b0;
                            st_d = ST_DROP;
                        end
                    end
                end
                default: begin
                    oe_d = 1'b0;
                end
            endcase
        end
    end

    // Purpose: protocol state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            txreg  <= '0;
            oe     <= 1'b0;
            a8     <= 1'b0;
            is_rd  <= 1'b0;
            mack   <= 1'b0;
        end else begin
            st     <= st_d;
            bitcnt <= bit_d;
            shreg  <= sh_d;
            txreg  <= tx_d;
            oe     <= oe_d;
            a8     <= a8_d;
            is_rd  <= rd_d;
            mack   <= mack_d;
        end
    end

    assign sda_oe_o = oe;
endmodule

// File: rtl/eep_serial_slave_chk.sv
// Module: protocol checker attached to eep_serial_slave by bind.
// Assumes it sees the synchronized SCL, the event pulses, the counter and
// its controls, and the protocol state.
module eep_serial_slave_chk #(
    parameter int AW = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_s,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic                sda_oe_o,
    input  logic [AW-1:0]       addr,
    input  logic                ctr_inc,
    input  logic                ctr_load,
    input  logic [AW-1:0]       load_val,
    input  eep_pkg::eep_state_t st
);
    import eep_pkg::*;

    // R10: drive changes only while SCL is low
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe_o) && !start_det && !stop_det) |-> !scl_s);

    // R4: counter takes the assembled address
    assert_addr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_load |=> addr == $past(load_val));

    // R5: increment advances by exactly one
    assert_addr_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_inc && !ctr_load) |=> addr == AW'($past(addr) + 1'b1));

    // R8: wrap from the top address to zero
    assert_addr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_inc && !ctr_load && addr == '1) |=> addr == '0);

    // R7: bus released while idle or ignoring
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DROP || st == ST_IDLE) |-> !sda_oe_o);

    // R9: START restarts command decoding
    assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> st == ST_CMD);

    // R9: STOP returns to idle
    assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> st == ST_IDLE);
endmodule

bind eep_serial_slave eep_serial_slave_chk #(.AW(eep_pkg::ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe_o  (sda_oe_o),
    .addr      (addr_q),
    .ctr_inc   (ctr_inc),
    .ctr_load  (ctr_load),
    .load_val  (load_val),
    .st        (st)
);

// File: tb/tb_eep_serial_slave.sv
module tb_eep_serial_slave;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe_o;
    int   vectors = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe_o;

    eep_serial_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe_o)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(((a % 512) * 29 + 11) ^ ((a % 512) >> 3));
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1;
        tick(Q); scl_m = 1'b1;
        tick(Q); sda_m = 1'b0;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0;
        tick(Q); scl_m = 1'b1;
        tick(Q); sda_m = 1'b1;
        tick(Q);
    endtask

    task automatic bit_out(logic b);
        tick(Q); sda_m = b;
        tick(Q); scl_m = 1'b1;
        tick(2 * Q); scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        tick(Q); sda_m = 1'b1;
        tick(Q); scl_m = 1'b1;
        tick(Q); b = sda_line;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        acked = ~b;
    endtask

    task automatic recv_byte(logic master_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~master_ack);
    endtask

    // Set the counter: write command with A8, address byte, then repeated START.
    task automatic set_addr(int a, string req);
        logic ack;
        bus_start();
        send_byte({4'b1010, 2'b00, 1'(a >> 8), 1'b0}, ack);
        chk(req, int'(ack), 1);
        send_byte(8'(a), ack);
        chk(req, int'(ack), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            report();
        end
    end

    initial begin
        logic       ack;
        logic [7:0] v;
        tick(6);
        rst_n = 1'b1;
        tick(6);

        // R1: released bus and zero contents after reset
        chk("R1 oe after reset", int'(sda_oe_o), 0);
        bus_start();
        send_byte(8'hA1, ack);
        chk("R1 read command ack", int'(ack), 1);
        recv_byte(1'b1, v);
        chk("R1 byte at counter 0", int'(v), 0);
        recv_byte(1'b0, v);
        chk("R1 byte at counter 1", int'(v), 0);
        bus_stop();

        // R2: wrong device code is not acknowledged and later bytes are ignored
        bus_start();
        send_byte(8'hB0, ack);
        chk("R2 bad command nack", int'(ack), 0);
        send_byte(8'h00, ack);
        chk("R2 ignored byte nack", int'(ack), 0);
        send_byte(8'hFF, ack);
        chk("R2 ignored byte nack", int'(ack), 0);
        bus_stop();

        // R3 R4 R5 R8: write cmd with bits 3,2 set and A8=1, block of 256 wraps past 511
        bus_start();
        send_byte(8'hAE, ack);
        chk("R3 write command ack", int'(ack), 1);
        send_byte(8'h80, ack);
        chk("R4 address byte ack", int'(ack), 1);
        for (int i = 0; i < 256; i++) begin
            send_byte(pat(384 + i), ack);
            chk("R5 data byte ack", int'(ack), 1);
        end
        bus_stop();

        // R6 R8: read cmd with bits 3..1 set, sequential read across the wrap
        set_addr(384, "R4 set address");
        bus_start();
        send_byte(8'hAF, ack);
        chk("R6 read command ack", int'(ack), 1);
        for (int i = 0; i < 256; i++) begin
            recv_byte(i != 255, v);
            chk((i == 128) ? "R8 byte after wrap" : "R6 sequential read",
                int'(v), int'(pat(384 + i)));
        end
        // R7: after master NACK the slave keeps the line released
        recv_byte(1'b0, v);
        chk("R7 released after nack", int'(v), 8'hFF);
        bus_stop();

        // R9: START in the middle of a data byte writes nothing
        set_addr(16, "R9 set address");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        set_addr(32, "R9 address after restart");
        send_byte(8'h5A, ack);
        chk("R5 data byte ack", int'(ack), 1);
        bus_stop();

        // R5: counter advanced after the write at 32
        bus_start();
        send_byte(8'hA1, ack);
        chk("R6 read command ack", int'(ack), 1);
        recv_byte(1'b0, v);
        chk("R5 counter advanced after write", int'(v), int'(pat(33)));
        bus_stop();

        set_addr(32, "R6 set address");
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b1, v);
        chk("R5 written byte", int'(v), 8'h5A);
        recv_byte(1'b0, v);
        chk("R6 next byte", int'(v), int'(pat(33)));
        bus_stop();

        set_addr(16, "R9 set address");
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, v);
        chk("R9 partial byte not written", int'(v), int'(pat(16)));
        bus_stop();

        // R2: bytes after a bad command leave counter and memory unchanged
        bus_start();
        send_byte(8'h30, ack);
        chk("R2 bad command nack", int'(ack), 0);
        send_byte(8'h00, ack);
        send_byte(8'hFF, ack);
        chk("R2 ignored byte nack", int'(ack), 0);
        bus_stop();
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, v);
        chk("R2 counter unchanged", int'(v), int'(pat(17)));
        bus_stop();
        set_addr(0, "R2 set address");
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, v);
        chk("R2 memory unchanged", int'(v), int'(pat(0)));
        bus_stop();

        // R10: line released at the end
        tick(8);
        chk("R10 oe idle at end", int'(sda_oe_o), 0);
        report();
    end
endmodule